// File: doc/BRIEF.md
# Logarithmic Shift and Rotate Unit

This block is a purely combinational datapath element that moves a word left or right by a variable number of bit positions. A three-bit operation code picks one of five behaviours: logical shift toward the high end, logical shift toward the low end, arithmetic shift toward the low end, and rotation in either direction. The result appears in the same cycle as the operands, so it can sit directly inside an execute stage and be registered by whatever follows it.

The unit is a cascade of log2(W) multiplexer layers. Layer k either passes its input through or moves it by 2^k places, depending on bit k of the amount. The layers run from the smallest distance to the largest. All five operations share this one cascade. What changes between them is the direction of the move and the source of the bits that enter the emptied positions: zeros, copies of the operand's original top bit, or the bits that fell off the opposite end.

Top module: `shf_barrel`

## Requirements
- R1: Operation code 3'b000 shifts the operand toward the high end by the amount, and the emptied low positions become 0.
- R2: Operation code 3'b001 shifts the operand toward the low end by the amount, and the emptied high positions become 0.
- R3: Operation code 3'b010 shifts the operand toward the low end by the amount, and the emptied high positions become copies of the operand's original bit W-1.
- R4: Operation code 3'b011 rotates toward the high end: bits leaving position W-1 re-enter at position 0, and the result has the same number of set bits as the operand.
- R5: Operation code 3'b100 rotates toward the low end: bits leaving position 0 re-enter at position W-1, and the result has the same number of set bits as the operand.
- R6: Operation codes 3'b101, 3'b110 and 3'b111 return the operand unchanged, whatever the amount.
- R7: An amount of 0 returns the operand unchanged for every operation code.
- R8: The result depends only on the present operand, amount and code, with no storage. The amount is log2(W) bits wide, W must be a power of two, and every amount from 0 to W-1 is valid.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| data_i | input | W | Operand to be moved |
| amt_i | input | log2(W) | Number of bit positions to move |
| op_i | input | 3 | Operation code (see R1 to R6) |
| data_o | output | W | Shifted or rotated result |

## Verification
The immediate checks assume that every input bit is driven to a known 0 or 1 and that W is a power of two, so that each amount covers the full range without wrapping. They are evaluated on settled combinational values. The stimulus therefore changes inputs only right after a rising clock edge and compares results at the falling edge. It walks all eight operation codes over every amount from 0 to W-1 for several operands. These operands include a set top bit, a clear top bit, all ones and sparse patterns, so each fill source is exercised at both extremes.

// File: rtl/shf_pkg.sv
package shf_pkg;

  typedef enum logic [2:0] {
    OP_SLL = 3'b000,
    OP_SRL = 3'b001,
    OP_SRA = 3'b010,
    OP_ROL = 3'b011,
    OP_ROR = 3'b100
  } shf_op_e;

  // control fields shared by every mux layer
  typedef struct packed {
    logic go_left;    // move toward the high end
    logic wrap;       // emptied places take the bits pushed out
    logic sign_fill;  // emptied high places take the original top bit
    logic bypass;     // result equals operand
  } shf_ctrl_t;

endpackage

// File: rtl/shf_decode.sv
module shf_decode
  import shf_pkg::*;
(
  input  logic [2:0] op_i,
  output shf_ctrl_t  ctrl_o
);

  always_comb begin
    ctrl_o = '0;
    unique case (op_i)
      OP_SLL: ctrl_o.go_left = 1'b1;
      OP_SRL: ctrl_o.go_left = 1'b0;
      OP_SRA: ctrl_o.sign_fill = 1'b1;
      OP_ROL: begin
        ctrl_o.go_left = 1'b1;
        ctrl_o.wrap    = 1'b1;
      end
      OP_ROR: ctrl_o.wrap = 1'b1;
      default: ctrl_o.bypass = 1'b1;
    endcase
  end

endmodule

// File: rtl/shf_stage.sv
module shf_stage
  import shf_pkg::*;
#(
  parameter int W = 32,
  parameter int D = 1
) (
  input  logic [W-1:0] d_i,
  input  logic         sel_i,
  input  shf_ctrl_t    ctrl_i,
  input  logic         sign_i,
  output logic [W-1:0] d_o
);

  logic [D-1:0] fill_lo;
  logic [D-1:0] fill_hi;
  logic [W-1:0] moved;

  always_comb begin
    fill_lo = ctrl_i.wrap ? d_i[W-1 -: D] : '0;
    if (ctrl_i.wrap)
      fill_hi = d_i[D-1:0];
    else if (ctrl_i.sign_fill)
      fill_hi = {D{sign_i}};
    else
      fill_hi = '0;
    moved = ctrl_i.go_left ? {d_i[W-1-D:0], fill_lo} : {fill_hi, d_i[W-1:D]};
    d_o   = sel_i ? moved : d_i;
  end

endmodule

// File: rtl/shf_barrel.sv
module shf_barrel
  import shf_pkg::*;
#(
  parameter int W = 32,
  localparam int AW = $clog2(W)
) (
  input  logic [W-1:0]  data_i,
  input  logic [AW-1:0] amt_i,
  input  logic [2:0]    op_i,
  output logic [W-1:0]  data_o
);

  shf_ctrl_t    ctrl;
  logic [W-1:0] chain [AW+1];

  shf_decode u_dec (
    .op_i   (op_i),
    .ctrl_o (ctrl)
  );

  assign chain[0] = data_i;

  for (genvar k = 0; k < AW; k++) begin : g_layer
    shf_stage #(.W(W), .D(1 << k)) u_stage (
      .d_i    (chain[k]),
      .sel_i  (amt_i[k]),
      .ctrl_i (ctrl),
      .sign_i (data_i[W-1]),
      .d_o    (chain[k+1])
    );
  end

  assign data_o = ctrl.bypass ? data_i : chain[AW];

endmodule

// File: rtl/shf_barrel_chk.sv
module shf_barrel_chk #(
  parameter int W = 32,
  localparam int AW = $clog2(W)
) (
  input logic [W-1:0]  data_i,
  input logic [AW-1:0] amt_i,
  input logic [2:0]    op_i,
  input logic [W-1:0]  data_o
);

  logic [W-1:0] lo_mask;
  logic [W-1:0] hi_mask;

  always_comb begin
    lo_mask = (W'(1) << amt_i) - W'(1);
    hi_mask = ~({W{1'b1}} >> amt_i);

    // R1
    sll_fill_chk: assert (op_i != 3'b000 || (data_o & lo_mask) == '0);
    // R2
    srl_fill_chk: assert (op_i != 3'b001 || (data_o & hi_mask) == '0);
    // R3
    sra_fill_chk: assert (op_i != 3'b010 ||
                          (data_o & hi_mask) == (data_i[W-1] ? hi_mask : '0));
    // R4
    rol_ones_chk: assert (op_i != 3'b011 || $countones(data_o) == $countones(data_i));
    // R5
    ror_ones_chk: assert (op_i != 3'b100 || $countones(data_o) == $countones(data_i));
    // R6
    spare_pass_chk: assert (op_i < 3'b101 || data_o == data_i);
    // R7
    zero_amt_chk: assert (amt_i != '0 || data_o == data_i);
  end

endmodule

bind shf_barrel shf_barrel_chk #(.W(W)) u_chk (
  .data_i (data_i),
  .amt_i  (amt_i),
  .op_i   (op_i),
  .data_o (data_o)
);

// File: tb/sim_shf_barrel.sv
module sim_shf_barrel;

  localparam int W  = 32;
  localparam int AW = $clog2(W);

  logic          clk;
  logic          rst_n;
  logic [W-1:0]  data_i;
  logic [AW-1:0] amt_i;
  logic [2:0]    op_i;
  logic [W-1:0]  data_o;

  int n_chk;
  int n_err;
  bit done;

  shf_barrel #(.W(W)) u0 (
    .data_i (data_i),
    .amt_i  (amt_i),
    .op_i   (op_i),
    .data_o (data_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // behavioural reference
  function automatic logic [W-1:0] model(input logic [W-1:0] d,
                                         input int a, input int op);
    logic [2*W-1:0] dbl;
    dbl = {d, d};
    case (op)
      0: return d << a;
      1: return d >> a;
      2: return W'($signed(d) >>> a);
      3: begin dbl = dbl << a; return dbl[2*W-1:W]; end
      4: begin dbl = dbl >> a; return dbl[W-1:0]; end
      default: return d;
    endcase
  endfunction

  function automatic string tag(input int op, input int a);
    if (a == 0) return "R7";
    case (op)
      0: return "R1";
      1: return "R2";
      2: return "R3";
      3: return "R4";
      4: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic compare(input logic [W-1:0] exp, input string req);
    n_chk++;
    if (data_o !== exp) begin
      n_err++;
      $display("FAIL %s op=%0d amt=%0d din=%h got=%h expected=%h",
               req, op_i, amt_i, data_i, data_o, exp);
    end
  endtask

  initial begin
    logic [W-1:0] pats [6];
    pats[0] = 32'h8000_0001;
    pats[1] = 32'hA5A5_F00F;
    pats[2] = 32'h7FFF_FFFF;
    pats[3] = 32'hFFFF_FFFF;
    pats[4] = 32'h1234_5678;
    pats[5] = 32'h8000_0000;
    n_chk = 0;
    n_err = 0;
    done  = 1'b0;
    rst_n  = 1'b0;
    data_i = '0;
    amt_i  = '0;
    op_i   = 3'b000;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R8: idle operands give a zero result, no stored state
    compare('0, "R8");
    @(posedge clk);
    rst_n = 1'b1;
    for (int p = 0; p < 6; p++) begin
      for (int op = 0; op < 8; op++) begin
        for (int a = 0; a < W; a++) begin
          @(posedge clk);
          data_i = pats[p];
          amt_i  = AW'(a);
          op_i   = 3'(op);
          @(negedge clk);
          // R8: result valid in the cycle the operands are applied
          compare(model(pats[p], a, op), tag(op, a));
        end
      end
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
      $finish;
    end
  end

endmodule